// File: doc/BRIEF.md
# Sv32 Set-Associative Translation Cache

This block caches recent Sv32 virtual-to-physical translations for one side of a core, either instruction fetch or data access. The lookup is purely combinational: a 32-bit virtual address goes in, and a hit flag and a 32-bit physical address come out in the same cycle. Ordinary 4 KiB pages and 4 MiB superpages share a single array of 8 sets by 2 ways. Each entry carries a size flag, so an entry only ever answers a probe of its own page size.

When a lookup misses, the page walker resolves the translation. It then presents the virtual address, the leaf PPN and a superpage flag on the fill port. The entry is written into the victim way of the set that the page size selects, and it can be used from the next cycle. A flush-all input empties the whole cache, for example when the address space changes.

Top module: `sv32_xlate_cache`

## Requirements
- R1: After reset, no lookup hits (lk_hit is 0 for every address) until a fill is made.
- R2: A lookup that hits a 4 KiB entry returns lk_pa = {stored PPN[19:0], lk_va[11:0]}.
- R3: A lookup that hits a superpage entry returns lk_pa = {stored PPN[19:10], lk_va[21:0]}. The low 10 PPN bits given at fill time are not used.
- R4: A 4 KiB entry is placed in set VA[14:12] and tagged with VA[31:15]. Two addresses that share bits 14:12 but differ in any bit 31:15 do not both hit the same entry.
- R5: A superpage entry is placed in set VA[24:22] and tagged with VA[31:25]. It hits for every address whose bits 31:22 equal those of the filled address, and for no other address.
- R6: A 4 KiB entry serves only its own 4 KiB page. A lookup elsewhere in the same 4 MiB region misses unless some other entry covers it.
- R7: Each set has its own victim pointer, which starts at way 0. A fill writes the pointed way and flips that set's pointer. A third distinct fill into a set therefore evicts the first, and fills to other sets leave the pointer alone.
- R8: flush_all clears every entry and every victim pointer from the next cycle on. A fill in the same cycle as the flush is dropped.
- R9: A fill is not visible to a lookup in its own cycle. It becomes visible in the next cycle.
- R10: When a 4 KiB entry and a superpage entry both match a lookup, the 4 KiB entry supplies the PA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_all | input | 1 | Invalidate all entries |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | 32 | Translated physical address, valid with lk_hit |
| fill_en | input | 1 | Write a new translation |
| fill_va | input | 32 | Virtual address being filled |
| fill_ppn | input | 20 | Leaf PPN from the page walker |
| fill_super | input | 1 | Fill is a 4 MiB superpage |

## Verification
The bench first targets conflict eviction. It fills three pages 0x8000 apart into one set and expects the oldest to miss; a design that kept one global pointer or did not flip the pointer would evict the wrong way. It also checks size separation: a 4 KiB fill must not answer a neighbouring page, a superpage must cover its whole 4 MiB region, and a design that ignored the size flag would return a false hit or a wrong PA. Further directed cases cover the 4 KiB-over-superpage priority, a fill dropped by a flush in the same cycle, and the one-cycle delay before a fill becomes visible. Random fills and lookups over a narrow address range then stress aliasing among sets against a bench model.

// File: rtl/sv32_xlate_cache.sv
module sv32_xlate_cache #(
  parameter int SETS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush_all,
  input  logic [31:0] lk_va,
  output logic        lk_hit,
  output logic [31:0] lk_pa,
  input  logic        fill_en,
  input  logic [31:0] fill_va,
  input  logic [19:0] fill_ppn,
  input  logic        fill_super
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = 20 - IDX_W;
  localparam int STAG_W = 10 - IDX_W;

  logic [1:0]       v_q   [SETS];
  logic [1:0]       sup_q [SETS];
  logic [TAG_W-1:0] tag_q [SETS][2];
  logic [19:0]      ppn_q [SETS][2];
  logic [SETS-1:0]  rr_q;

  logic [IDX_W-1:0] s4, ss, fset;
  logic             fway;
  logic [TAG_W-1:0] ftag;
  logic [1:0]       hit4, hits;
  logic             w4, ws;

  assign s4 = lk_va[12 +: IDX_W];
  assign ss = lk_va[22 +: IDX_W];

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign hit4[w] = v_q[s4][w] & ~sup_q[s4][w] & (tag_q[s4][w] == lk_va[31:12+IDX_W]);
    assign hits[w] = v_q[ss][w] &  sup_q[ss][w] & (tag_q[ss][w] == TAG_W'(lk_va[31:22+IDX_W]));
  end

  assign w4 = hit4[1] & ~hit4[0];
  assign ws = hits[1] & ~hits[0];
  assign lk_hit = |hit4 | |hits;
  assign lk_pa = |hit4 ? {ppn_q[s4][w4], lk_va[11:0]}
                       : {ppn_q[ss][ws][19:10], lk_va[21:0]};

  assign fset = fill_super ? fill_va[22 +: IDX_W] : fill_va[12 +: IDX_W];
  assign fway = rr_q[fset];
  assign ftag = fill_super ? TAG_W'(fill_va[31:22+IDX_W]) : fill_va[31:12+IDX_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_q <= '0;
      for (int s = 0; s < SETS; s++) v_q[s] <= '0;
    end else if (flush_all) begin
      rr_q <= '0;
      for (int s = 0; s < SETS; s++) v_q[s] <= '0;
    end else if (fill_en) begin
      v_q[fset][fway] <= 1'b1;
      rr_q[fset]      <= ~fway;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !flush_all) begin
      tag_q[fset][fway] <= ftag;
      ppn_q[fset][fway] <= fill_ppn;
      sup_q[fset][fway] <= fill_super;
    end
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> !lk_hit); // R8

  AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush_all) ##1 (lk_va == $past(fill_va)) |-> lk_hit); // R9

  AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush_all) |=> v_q[$past(fset)][$past(fway)]); // R7

  AST_RR_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush_all) |=> rr_q[$past(fset)] != $past(rr_q[fset])); // R7

  AST_FLUSH_RR_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> rr_q == '0); // R8
endmodule

// File: tb/sv32_xlate_cache_test.sv
`timescale 1ns/1ps
module sv32_xlate_cache_test;
  logic        clk = 0, rst_n = 0, flush_all = 0;
  logic [31:0] lk_va = 0, fill_va = 0;
  logic        fill_en = 0, fill_super = 0;
  logic [19:0] fill_ppn = 0;
  logic        lk_hit;
  logic [31:0] lk_pa;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sv32_xlate_cache uut (.clk, .rst_n, .flush_all, .lk_va, .lk_hit, .lk_pa,
                        .fill_en, .fill_va, .fill_ppn, .fill_super);

  bit        mv[8][2], ms[8][2], mrr[8];
  logic [19:0] mpg[8][2];
  logic [19:0] mppn[8][2];

  function automatic void model_lookup(input logic [31:0] va, output bit h, output logic [31:0] pa);
    h = 0; pa = 0;
    for (int w = 0; w < 2; w++) begin
      int s = va[14:12];
      if (!h && mv[s][w] && !ms[s][w] && mpg[s][w] == va[31:12]) begin h = 1; pa = {mppn[s][w], va[11:0]}; end
    end
    for (int w = 0; w < 2; w++) begin
      int s = va[24:22];
      if (!h && mv[s][w] && ms[s][w] && mpg[s][w][19:10] == va[31:22]) begin h = 1; pa = {mppn[s][w][19:10], va[21:0]}; end
    end
  endfunction

  function automatic void model_clear();
    for (int s = 0; s < 8; s++) begin mrr[s] = 0; mv[s][0] = 0; mv[s][1] = 0; end
  endfunction

  task automatic check(input string req, input logic [31:0] va, input bit eh, input logic [31:0] epa);
    lk_va = va; #1;
    checks++;
    if (lk_hit !== eh || (eh && lk_pa !== epa)) begin
      errors++;
      $display("FAIL %s va=%h: hit=%0d pa=%h expected hit=%0d pa=%h", req, va, lk_hit, lk_pa, eh, epa);
    end
  endtask

  task automatic check_model(input string req, input logic [31:0] va);
    bit h; logic [31:0] pa;
    model_lookup(va, h, pa);
    check(req, va, h, pa);
  endtask

  task automatic fill(input logic [31:0] va, input logic [19:0] ppn, input bit sup, input bit fl = 0);
    int s;
    @(negedge clk);
    fill_en = 1; fill_va = va; fill_ppn = ppn; fill_super = sup; flush_all = fl;
    lk_va = va; #1;
    if (!fl) begin
      bit h; logic [31:0] pa;
      model_lookup(va, h, pa);
      check("R9", va, h, pa);
    end
    @(posedge clk); #0.1;
    fill_en = 0; flush_all = 0;
    if (fl) model_clear();
    else begin
      s = sup ? va[24:22] : va[14:12];
      mv[s][mrr[s]] = 1; ms[s][mrr[s]] = sup; mpg[s][mrr[s]] = va[31:12]; mppn[s][mrr[s]] = ppn;
      mrr[s] = !mrr[s];
    end
  endtask

  task automatic flush();
    @(negedge clk); flush_all = 1;
    @(posedge clk); #0.1; flush_all = 0; model_clear();
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_clear();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1", 32'h0040_1000, 0, 0);
    check("R1", 32'h0000_0000, 0, 0);

    fill(32'h0000_1000, 20'h12345, 0);
    @(negedge clk);
    check("R2", 32'h0000_1ABC, 1, 32'h1234_5ABC);
    check("R4", 32'h0000_9ABC, 0, 0);
    check("R6", 32'h0000_2ABC, 0, 0);

    fill(32'h0040_0000, 20'hABC77, 1);
    @(negedge clk);
    check("R3", 32'h0052_3456, 1, 32'hABD2_3456);
    check("R5", 32'h007F_F004, 1, 32'hABFF_F004);
    check("R5", 32'h0252_3456, 0, 0);

    fill(32'h0000_0000, 20'h55500, 1);
    fill(32'h0000_0000, 20'h11111, 0);
    @(negedge clk);
    check("R10", 32'h0000_0123, 1, 32'h1111_1123);
    check("R10", 32'h0000_3123, 1, 32'h5540_3123);

    flush();
    @(negedge clk);
    check("R8", 32'h0000_1ABC, 0, 0);
    check("R8", 32'h0052_3456, 0, 0);

    fill(32'h0000_1000, 20'h00A01, 0);
    fill(32'h0000_3000, 20'h00A03, 0);
    fill(32'h0000_9000, 20'h00A09, 0);
    fill(32'h0001_1000, 20'h00A11, 0);
    @(negedge clk);
    check("R7", 32'h0000_1004, 0, 0);
    check("R7", 32'h0000_9004, 1, 32'h00A0_9004);
    check("R7", 32'h0001_1004, 1, 32'h00A1_1004);
    check("R7", 32'h0000_3004, 1, 32'h00A0_3004);
    fill(32'h0001_9000, 20'h00A19, 0);
    @(negedge clk);
    check("R7", 32'h0000_9004, 0, 0);
    check("R7", 32'h0001_9004, 1, 32'h00A1_9004);

    fill(32'h0006_6000, 20'h0BEEF, 0, 1);
    @(negedge clk);
    check("R8", 32'h0006_6000, 0, 0);
    check("R8", 32'h0001_9004, 0, 0);
    fill(32'h0000_1000, 20'h00B01, 0);
    fill(32'h0000_9000, 20'h00B09, 0);
    @(negedge clk);
    check("R8", 32'h0000_1000, 1, 32'h00B0_1000);
    check("R8", 32'h0000_9000, 1, 32'h00B0_9000);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] va;
      va = $urandom & 32'h03C3_FFFF;
      if ($urandom_range(0, 3) == 0) begin
        bit sup;
        sup = $urandom_range(0, 1);
        fill(va, sup ? {va[31:22] ^ 10'h2A5, 10'h3FF} : va[31:12] ^ 20'h5A5A5, sup);
      end else if ($urandom_range(0, 99) == 0) begin
        flush();
      end else begin
        @(negedge clk);
        check_model(i[0] ? "R4" : "R5", va);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule